// File: doc/BRIEF.md
# Pixel Array Scan Sequencer

This block drives the readout of a square pixel array whose pixels share a single comparator. When started, it issues a global photodiode reset pulse and then produces row and column addresses together with a sample strobe. Each strobe tells the downstream threshold logic to take one comparator decision for the pixel that is currently addressed. The sample rate comes from a programmable divider. This gives the externally modulated threshold time to settle between decisions.

The sequencer has two modes. In full-frame mode it sweeps the whole array in raster order, with the column changing fastest, and strobes each pixel once per pass. It repeats the pass until each pixel has received the requested number of samples. In single-pixel mode it walks the address one raster position per clock from the origin to a chosen pixel, with no strobes during the walk. It then stays on that pixel and issues all requested samples back to back. A sample index output tells the downstream logic which pass, or which dwell sample, is in progress. A one-cycle done flag marks the end of the exposure.

The control state machine has five states. IDLE waits for start. RESET drives the reset pulse. SEEK walks the address in single-pixel mode. SAMPLE strobes at the divided rate. DONE raises the done flag.

The transitions are:
- start-accept: IDLE to RESET.
- reset-to-frame: RESET to SAMPLE, taken in full-frame mode when the reset count expires.
- reset-to-walk: RESET to SEEK, taken in single-pixel mode when the reset count expires.
- target-reached: SEEK to SAMPLE.
- final-sample: SAMPLE to DONE.
- finish: DONE to IDLE.

Top module: `pix_scan_seq`

## Requirements
- R1: After reset is released, `pix_reset`, `sample_stb`, `frame_done` and `busy` are low, and `row_addr`, `col_addr` and `sample_idx` are zero.
- R2: A `start` pulse seen in IDLE raises `pix_reset` for exactly RST_CYC consecutive cycles (default 4). No strobe occurs before those cycles have ended.
- R3: In full-frame mode (`mode` = 0), successive strobes step `col_addr` by one. When `col_addr` wraps from COLS-1 to 0, `row_addr` steps by one. Each pass strobes every pixel exactly once, starting at (0,0).
- R4: In full-frame mode, `sample_idx` holds the pass number during every strobe and increases when the scan returns to (0,0). One exposure gives nsamp × ROWS × COLS strobes.
- R5: In single-pixel mode (`mode` = 1), after the reset pulse the raster address advances by one position per clock from (0,0) to the target, with no strobe. The number of strobe-free busy cycles after the reset pulse is (target_row × COLS + target_col) + 1 + `div`.
- R6: In single-pixel mode, exactly nsamp strobes occur. All of them are at the target address, and `sample_idx` runs 0, 1, … nsamp-1.
- R7: Consecutive strobes are exactly `div` + 1 clock cycles apart.
- R8: `frame_done` is high for exactly one cycle, in the cycle right after the final strobe. `busy` is low in the following cycle.
- R9: A requested sample count of zero is treated as one.
- R10: A `start` pulse while `busy` is high has no effect. The running exposure keeps its mode, count and strobe sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an exposure; used only in IDLE |
| mode | input | 1 | 0 = full-frame raster, 1 = single-pixel dwell; latched at start |
| tgt_row | input | ROW_W (7) | Single-pixel target row, latched at start |
| tgt_col | input | COL_W (7) | Single-pixel target column, latched at start |
| nsamp | input | SAMP_W (10) | Samples per pixel; zero means one |
| div | input | DIV_W (8) | Strobe period minus one, in clock cycles |
| row_addr | output | ROW_W (7) | Current row address |
| col_addr | output | COL_W (7) | Current column address |
| pix_reset | output | 1 | Global photodiode reset |
| sample_stb | output | 1 | One-cycle comparator sample strobe |
| sample_idx | output | SAMP_W (10) | Pass number (full-frame) or dwell sample number |
| frame_done | output | 1 | One-cycle end-of-exposure flag |
| busy | output | 1 | High whenever the state is not IDLE |

## Verification
The bench runs full-frame exposures with two passes at the fastest rate, and with one pass at half rate. These show whether the raster order, the row carry and the pass counting are right, and whether the divider spacing holds across every row boundary.

Single-pixel exposures are aimed at a target near the origin, at the origin itself with a zero count, and at the last pixel of the array. These show the length of the walk, the hold on the target, the conversion of a zero count to one, and the handling of the final raster position.

One full-frame run receives a conflicting `start` in mid-scan. This shows whether the running exposure really ignores it.

// File: rtl/scan_pkg.sv
package scan_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RESET,
        ST_SEEK,
        ST_SAMPLE,
        ST_DONE
    } scan_state_t;
endpackage

// File: rtl/scan_rate_div.sv
module scan_rate_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] lim,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || cnt_q == lim)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run && (cnt_q == lim);
endmodule

// File: rtl/scan_addr.sv
module scan_addr #(
    parameter int ROWS = 128,
    parameter int COLS = 128,
    localparam int ROW_W = $clog2(ROWS),
    localparam int COL_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    output logic [ROW_W-1:0] row,
    output logic [COL_W-1:0] col,
    output logic             at_end
);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row <= '0;
            col <= '0;
        end else if (clr) begin
            row <= '0;
            col <= '0;
        end else if (step) begin
            if (col == COL_LAST) begin
                col <= '0;
                row <= (row == ROW_LAST) ? '0 : row + 1'b1;
            end else begin
                col <= col + 1'b1;
            end
        end
    end

    assign at_end = (row == ROW_LAST) && (col == COL_LAST);
endmodule

// File: rtl/pix_scan_seq.sv
module pix_scan_seq
    import scan_pkg::*;
#(
    parameter int ROWS    = 128,
    parameter int COLS    = 128,
    parameter int SAMP_W  = 10,
    parameter int DIV_W   = 8,
    parameter int RST_CYC = 4,
    localparam int ROW_W  = $clog2(ROWS),
    localparam int COL_W  = $clog2(COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode,
    input  logic [ROW_W-1:0]  tgt_row,
    input  logic [COL_W-1:0]  tgt_col,
    input  logic [SAMP_W-1:0] nsamp,
    input  logic [DIV_W-1:0]  div,
    output logic [ROW_W-1:0]  row_addr,
    output logic [COL_W-1:0]  col_addr,
    output logic              pix_reset,
    output logic              sample_stb,
    output logic [SAMP_W-1:0] sample_idx,
    output logic              frame_done,
    output logic              busy
);
    localparam int RC_W = $clog2(RST_CYC + 1);
    localparam logic [RC_W-1:0] RC_LAST = RC_W'(RST_CYC - 1);

    scan_state_t       state_q, state_d;
    logic              mode_q;
    logic [ROW_W-1:0]  tgt_row_q;
    logic [COL_W-1:0]  tgt_col_q;
    logic [SAMP_W-1:0] last_q;
    logic [DIV_W-1:0]  div_q;
    logic [RC_W-1:0]   rst_cnt_q;
    logic [SAMP_W-1:0] idx_q;

    logic accept, tick, last_pix, at_tgt, final_smp, step, idx_inc;

    assign accept = (state_q == ST_IDLE) && start;
    assign at_tgt = (row_addr == tgt_row_q) && (col_addr == tgt_col_q);

    scan_rate_div #(.DIV_W(DIV_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state_q == ST_SAMPLE),
        .lim  (div_q),
        .tick (tick)
    );

    scan_addr #(.ROWS(ROWS), .COLS(COLS)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .step  (step),
        .row   (row_addr),
        .col   (col_addr),
        .at_end(last_pix)
    );

    // final sample of the exposure: last dwell sample, or last pixel of last pass
    assign final_smp = (idx_q == last_q) && (mode_q || last_pix);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_RESET;
            ST_RESET:  if (rst_cnt_q == RC_LAST) state_d = mode_q ? ST_SEEK : ST_SAMPLE;
            ST_SEEK:   if (at_tgt) state_d = ST_SAMPLE;
            ST_SAMPLE: if (tick && final_smp) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs and per-state controls
    always_comb begin
        pix_reset  = 1'b0;
        sample_stb = 1'b0;
        frame_done = 1'b0;
        step       = 1'b0;
        idx_inc    = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_RESET:  pix_reset = 1'b1;
            ST_SEEK:   step = !at_tgt;
            ST_SAMPLE: begin
                sample_stb = tick;
                step       = tick && !mode_q && !final_smp;
                idx_inc    = tick && !final_smp && (mode_q || last_pix);
            end
            ST_DONE:   frame_done = 1'b1;
            default:   ;
        endcase
    end

    assign busy       = (state_q != ST_IDLE);
    assign sample_idx = idx_q;

    // exposure settings captured at start, reset counter, sample index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= 1'b0;
            tgt_row_q <= '0;
            tgt_col_q <= '0;
            last_q    <= '0;
            div_q     <= '0;
            rst_cnt_q <= '0;
            idx_q     <= '0;
        end else begin
            if (accept) begin
                mode_q    <= mode;
                tgt_row_q <= tgt_row;
                tgt_col_q <= tgt_col;
                last_q    <= (nsamp == '0) ? '0 : nsamp - 1'b1;
                div_q     <= div;
                idx_q     <= '0;
            end else if (idx_inc) begin
                idx_q <= idx_q + 1'b1;
            end
            rst_cnt_q <= (state_q == ST_RESET) ? rst_cnt_q + 1'b1 : '0;
        end
    end
endmodule

// File: rtl/scan_chk.sv
module scan_chk #(
    parameter int ROWS  = 128,
    parameter int COLS  = 128,
    parameter int DIV_W = 8,
    localparam int ROW_W = $clog2(ROWS),
    localparam int COL_W = $clog2(COLS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_q,
    input logic [DIV_W-1:0] div_q,
    input logic             pix_reset,
    input logic             sample_stb,
    input logic             frame_done,
    input logic [ROW_W-1:0] row_addr,
    input logic [COL_W-1:0] col_addr
);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);

    p_reset_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pix_reset |-> !sample_stb);

    p_col_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && !mode_q && col_addr != COL_LAST) |=>
            (col_addr == $past(col_addr) + 1'b1) && (row_addr == $past(row_addr)));

    p_row_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && !mode_q && col_addr == COL_LAST && row_addr != ROW_LAST) |=>
            (col_addr == '0) && (row_addr == $past(row_addr) + 1'b1));

    p_dwell_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && mode_q) |=> $stable(row_addr) && $stable(col_addr));

    p_stb_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && div_q != '0) |=> !sample_stb);

    p_done_after_stb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(sample_stb));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
endmodule

bind pix_scan_seq scan_chk #(.ROWS(ROWS), .COLS(COLS), .DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_q    (mode_q),
    .div_q     (div_q),
    .pix_reset (pix_reset),
    .sample_stb(sample_stb),
    .frame_done(frame_done),
    .row_addr  (row_addr),
    .col_addr  (col_addr)
);

// File: tb/tb_pix_scan_seq.sv
`timescale 1ns/1ps
module tb_pix_scan_seq;
    localparam int ROWS = 128, COLS = 128, SAMP_W = 10, DIV_W = 8, RST_CYC = 4;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode = 1'b0;
    logic [6:0] tgt_row = '0, tgt_col = '0;
    logic [SAMP_W-1:0] nsamp = '0;
    logic [DIV_W-1:0] div = '0;
    logic [6:0] row_addr, col_addr;
    logic pix_reset, sample_stb, frame_done, busy;
    logic [SAMP_W-1:0] sample_idx;

    always #2.5 clk = ~clk;

    pix_scan_seq #(.ROWS(ROWS), .COLS(COLS), .SAMP_W(SAMP_W), .DIV_W(DIV_W), .RST_CYC(RST_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .tgt_row(tgt_row), .tgt_col(tgt_col),
        .nsamp(nsamp), .div(div), .row_addr(row_addr), .col_addr(col_addr), .pix_reset(pix_reset),
        .sample_stb(sample_stb), .sample_idx(sample_idx), .frame_done(frame_done), .busy(busy));

    int n_chk = 0, n_fail = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // negedge monitor with an independent model of the expected strobe sequence
    bit mon_on = 0, m_single = 0;
    int cyc = 0, m_div = 0, m_tr = 0, m_tc = 0;
    int sc, seq_err, gap_err, last_stb, rcnt, early_stb, pre_cyc, seek_err, prev_lin;
    int done_cnt, done_bad, e_row, e_col, e_idx;
    bit prev_stb;

    always @(negedge clk) begin
        cyc++;
        if (mon_on) begin
            if (pix_reset) rcnt++;
            if (sample_stb) begin
                if (rcnt != RST_CYC) early_stb++;
                if (int'(row_addr) != e_row || int'(col_addr) != e_col || int'(sample_idx) != e_idx)
                    seq_err++;
                if (sc > 0 && (cyc - last_stb) != m_div + 1) gap_err++;
                last_stb = cyc;
                sc++;
                if (m_single) e_idx++;
                else begin
                    e_col++;
                    if (e_col == COLS) begin
                        e_col = 0; e_row++;
                        if (e_row == ROWS) begin e_row = 0; e_idx++; end
                    end
                end
            end else if (busy && !pix_reset && sc == 0 && !frame_done) begin
                pre_cyc++;
                if (int'(row_addr) * COLS + int'(col_addr) < prev_lin ||
                    int'(row_addr) * COLS + int'(col_addr) > prev_lin + 1) seek_err++;
                prev_lin = int'(row_addr) * COLS + int'(col_addr);
            end
            if (frame_done) begin
                done_cnt++;
                if (!prev_stb) done_bad++;
            end
            prev_stb = sample_stb;
        end
    end

    task automatic launch(input bit md, input int tr, input int tc, input int ns, input int dv);
        sc = 0; seq_err = 0; gap_err = 0; last_stb = 0; rcnt = 0; early_stb = 0;
        pre_cyc = 0; seek_err = 0; prev_lin = 0; done_cnt = 0; done_bad = 0; prev_stb = 0;
        m_single = md; m_div = dv; m_tr = tr; m_tc = tc;
        e_row = md ? tr : 0; e_col = md ? tc : 0; e_idx = 0;
        @(negedge clk);
        mode = md; tgt_row = 7'(tr); tgt_col = 7'(tc); nsamp = SAMP_W'(ns); div = DIV_W'(dv);
        start = 1'b1; mon_on = 1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_run(input string tag, input int exp_stb, input int exp_pre);
        while (done_cnt == 0) @(negedge clk);
        @(negedge clk);
        chk({tag, " R8 busy low after done"}, int'(busy), 0);
        mon_on = 0;
        chk({tag, " R2 reset pulse length"}, rcnt, RST_CYC);
        chk({tag, " R2 strobe before reset end"}, early_stb, 0);
        chk({tag, " R3/R6 strobe sequence errors"}, seq_err, 0);
        chk({tag, " R4/R6 strobe count"}, sc, exp_stb);
        chk({tag, " R7 strobe spacing errors"}, gap_err, 0);
        chk({tag, " R5 strobe-free cycles after reset"}, pre_cyc, exp_pre);
        chk({tag, " R5 walk order errors"}, seek_err, 0);
        chk({tag, " R8 done pulses"}, done_cnt, 1);
        chk({tag, " R8 done not after final strobe"}, done_bad, 0);
    endtask

    task automatic t_reset_state;
        chk("R1 pix_reset", int'(pix_reset), 0);
        chk("R1 sample_stb", int'(sample_stb), 0);
        chk("R1 frame_done", int'(frame_done), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 row_addr", int'(row_addr), 0);
        chk("R1 col_addr", int'(col_addr), 0);
        chk("R1 sample_idx", int'(sample_idx), 0);
    endtask

    task automatic t_single_near;
        launch(1'b1, 2, 5, 6, 3);
        finish_run("single(2,5)", 6, 2 * COLS + 5 + 1 + 3);
    endtask

    task automatic t_single_zero_count;
        launch(1'b1, 0, 0, 0, 0);
        finish_run("single(0,0) R9 count zero", 1, 1);
    endtask

    task automatic t_full_two_pass;
        launch(1'b0, 0, 0, 2, 0);
        finish_run("full x2", 2 * ROWS * COLS, 0);
        chk("R4 final pass index", int'(sample_idx), 1);
    endtask

    task automatic t_full_ignore_start;
        launch(1'b0, 0, 0, 1, 1);
        repeat (100) @(negedge clk);
        mode = 1'b1; tgt_row = 7'd9; tgt_col = 7'd9; nsamp = 10'd5; div = 8'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        finish_run("full R10 ignored start", ROWS * COLS, 1);
    endtask

    task automatic t_single_last;
        launch(1'b1, ROWS - 1, COLS - 1, 3, 2);
        finish_run("single(last)", 3, ROWS * COLS + 2);
        chk("R6 final dwell index", int'(sample_idx), 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_single_near();
        t_single_zero_count();
        t_full_two_pass();
        t_full_ignore_start();
        t_single_last();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R8: actual no finish expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule